// File: doc/BRIEF.md
# Jittered PWM Duty Limiter

This block is the digital heart of a peak current-mode switching controller. It divides the system clock into switching periods whose length sweeps in a slow triangle about a programmed nominal count, which spreads the converter's emission spectrum by roughly five percent either side of the centre frequency. At the first cycle of every period it raises the gate-drive pulse, provided the controller is enabled and the feedback level does not call for skipping.

The pulse ends at the earliest of three events. The first is the duty ceiling of the selected variant. The second is a current-sense trip, either against the feedback setpoint or against the soft-start limit, once the blanking window after turn-on has passed. The third is the end of the minimum on-time while feedback sits in its low region. A small hysteretic state machine tracks the skip region from three feedback comparator flags. The comparators, the ramp compensation and the start-up sequencing sit outside the block and reach it only as single-bit flags and an enable.

Top module: `pwm_duty_limiter`

## Requirements
- R1: Each switching period lasts exactly `period_nom_i` plus the current jitter offset in clock cycles, and `tick_o` is high in the last cycle of every period.
- R2: The jitter offset starts at 0 and rising. At every JIT_EVERY-th period start it moves by one count. While rising, it increments until it equals +A, where A = (period_nom_i * 13) >> 8. The next step reverses direction and decrements instead. While falling, it mirrors this at -A.
- R3: The pulse ceiling in cycles is (period length * K) >> 8. K is 128 for `variant_i` = 0 (half), 204 for 1 (about 80%), 166 for 2 (about 65%) and 121 for 3 (about 47.5%). The ceiling is computed from the length of the period just starting.
- R4: A pulse can only rise in the first cycle of a period. Variant and ceiling are latched at that point.
- R5: The gate never stays high for more cycles than the latched ceiling, whatever the trip inputs do.
- R6: Either `cs_trip_i` or `ss_trip_i` that is high in the k-th high cycle ends the pulse after k cycles, when k is beyond the blanking window and at least the minimum on-time.
- R7: A trip in the first BLANK_CYC high cycles is ignored. If no later trip occurs, the pulse runs to its ceiling.
- R8: A pulse that is not cut short by the ceiling or the enable lasts at least MIN_ON_CYC cycles. A trip seen after blanking but before that point ends the pulse at exactly MIN_ON_CYC.
- R9: With `fb_above_min_i` low and skip inactive, every pulse lasts min(MIN_ON_CYC, ceiling) cycles, independent of trips.
- R10: Skip is entered one cycle after `fb_above_skip_i` is low and is left only once `fb_above_exit_i` is high. No pulse starts while skip is active.
- R11: With `en_i` low, the gate falls on the next clock edge and no pulse starts.
- R12: During reset the gate is low. The first period begins at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_nom_i | input | PER_W | Nominal switching period in clock cycles |
| variant_i | input | 2 | Duty-ceiling variant code (see R3) |
| en_i | input | 1 | Switching allowed, from the sequencer |
| cs_trip_i | input | 1 | Current sense above feedback setpoint |
| ss_trip_i | input | 1 | Current sense above soft-start limit / 4 |
| fb_above_min_i | input | 1 | Feedback above the minimum on-time level |
| fb_above_skip_i | input | 1 | Feedback above the skip entry level |
| fb_above_exit_i | input | 1 | Feedback above skip level plus hysteresis |
| gate_o | output | 1 | Gate-drive pulse |
| tick_o | output | 1 | High in the last cycle of each period |

## Verification
The bench places trips on both sides of the blanking boundary. A design that counted the window one cycle short would cut the pulse at the minimum on-time instead of letting it run to the ceiling. Trips between blanking and the minimum on-time, and trips past the ceiling, expose a pulse that is too short or one that overshoots the duty limit. The feedback flag is held inside the hysteresis band from both sides, which catches a skip that leaves at the entry level or never leaves. The jitter run follows offsets through both turning points and checks each period length and its scaled ceiling, so an off-by-one at a reversal or a ceiling taken from the previous period shows up as a length or width mismatch.

// File: rtl/pwm_lim_pkg.sv
package pwm_lim_pkg;

    typedef enum logic [1:0] {
        VAR_HALF      = 2'd0,
        VAR_EIGHTY    = 2'd1,
        VAR_SIXTYFIVE = 2'd2,
        VAR_LOW       = 2'd3
    } duty_var_e;

    localparam int FRAC_W = 8;

    // Duty ceiling numerator over 2^FRAC_W
    function automatic logic [FRAC_W-1:0] duty_num(input duty_var_e v);
        logic [FRAC_W-1:0] k;
        case (v)
            VAR_HALF:      k = 8'd128;
            VAR_EIGHTY:    k = 8'd204;
            VAR_SIXTYFIVE: k = 8'd166;
            default:       k = 8'd121;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/pwm_period_jitter.sv
module pwm_period_jitter #(
    parameter int PER_W     = 12,
    parameter int JIT_NUM   = 13,
    parameter int JIT_EVERY = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] nom_i,
    output logic             tick_o,
    output logic [PER_W-1:0] next_len_o
);
    localparam int OFF_W  = PER_W + 1;
    localparam int STEP_W = (JIT_EVERY > 1) ? $clog2(JIT_EVERY) : 1;
    localparam logic [7:0] JIT_K = JIT_NUM[7:0];
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(JIT_EVERY - 1);
    localparam logic signed [OFF_W-1:0] ONE_S = 1;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] len;
        logic [OFF_W-1:0] off;
        logic             up;
        logic [STEP_W-1:0] step;
    } jit_st_t;

    jit_st_t s_d, s_q;

    logic [PER_W+7:0]        amp_prod;
    logic signed [OFF_W-1:0] amp;
    logic signed [OFF_W-1:0] off_q_s;
    logic signed [OFF_W-1:0] off_n;
    logic signed [OFF_W-1:0] len_sum;
    logic                    tick;

    always_comb begin
        s_d      = s_q;
        amp_prod = {8'b0, nom_i} * {{PER_W{1'b0}}, JIT_K};
        amp      = $signed({1'b0, amp_prod[PER_W+7:8]});
        off_q_s  = $signed(s_q.off);
        off_n    = off_q_s;
        tick     = ({1'b0, s_q.cnt} + {{PER_W{1'b0}}, 1'b1}) >= {1'b0, s_q.len};
        len_sum  = '0;
        if (tick) begin
            s_d.cnt = '0;
            if (s_q.step == STEP_LAST) begin
                s_d.step = '0;
                if (s_q.up) begin
                    if (off_q_s < amp) begin
                        off_n = off_q_s + ONE_S;
                    end else begin
                        s_d.up = 1'b0;
                        if (off_q_s > -amp) off_n = off_q_s - ONE_S;
                    end
                end else begin
                    if (off_q_s > -amp) begin
                        off_n = off_q_s - ONE_S;
                    end else begin
                        s_d.up = 1'b1;
                        if (off_q_s < amp) off_n = off_q_s + ONE_S;
                    end
                end
            end else begin
                s_d.step = s_q.step + 1'b1;
            end
            len_sum  = $signed({1'b0, nom_i}) + off_n;
            s_d.off  = off_n;
            s_d.len  = len_sum[PER_W-1:0];
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.len  <= PER_W'(1);
            s_q.up   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tick_o     = tick;
    assign next_len_o = s_d.len;

    // R2: offset moves by at most one count per clock
    a_r2_off_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(s_q.off) == $signed($past(s_q.off))) ||
        ($signed(s_q.off) == $signed($past(s_q.off)) + ONE_S) ||
        ($signed(s_q.off) == $signed($past(s_q.off)) - ONE_S));

    // R1: the position counter stays inside the period
    a_r1_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < s_q.len);

endmodule

// File: rtl/pwm_fb_mode.sv
module pwm_fb_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_above_skip_i,
    input  logic fb_above_exit_i,
    output logic skip_o
);
    typedef struct packed {
        logic skip;
    } fb_st_t;

    fb_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!fb_above_skip_i)      s_d.skip = 1'b1;
        else if (fb_above_exit_i)  s_d.skip = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign skip_o = s_q.skip;

    // R10: entry follows a low skip flag
    a_r10_skip_entry: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_above_skip_i |=> s_q.skip);

    // R10: exit needs the upper hysteresis level
    a_r10_skip_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.skip) |-> $past(fb_above_exit_i));

endmodule

// File: rtl/pwm_pulse_gate.sv
module pwm_pulse_gate
    import pwm_lim_pkg::*;
#(
    parameter int PER_W      = 12,
    parameter int BLANK_CYC  = 20,
    parameter int MIN_ON_CYC = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [PER_W-1:0] next_len_i,
    input  logic [1:0]       variant_i,
    input  logic             skip_i,
    input  logic             min_mode_i,
    input  logic             trip_i,
    output logic             gate_o
);
    localparam logic [PER_W-1:0] BLANK_L = PER_W'(BLANK_CYC);
    localparam logic [PER_W-1:0] MIN_L   = PER_W'(MIN_ON_CYC);

    typedef struct packed {
        logic             gate;
        logic             seen;
        logic [PER_W-1:0] on_len;
        logic [PER_W-1:0] maxon;
    } gate_st_t;

    gate_st_t s_d, s_q;

    logic [PER_W+7:0] ceil_prod;
    logic             trip_ok;
    logic             hit_max;
    logic             min_ok;

    always_comb begin
        s_d       = s_q;
        ceil_prod = {8'b0, next_len_i} *
                    {{PER_W{1'b0}}, duty_num(duty_var_e'(variant_i))};
        trip_ok   = trip_i && (s_q.on_len > BLANK_L);
        hit_max   = s_q.on_len >= s_q.maxon;
        min_ok    = s_q.on_len >= MIN_L;
        if (!en_i) begin
            s_d.gate   = 1'b0;
            s_d.seen   = 1'b0;
            s_d.on_len = '0;
        end else if (tick_i) begin
            s_d.maxon  = ceil_prod[PER_W+7:8];
            s_d.gate   = !skip_i && (ceil_prod[PER_W+7:8] != '0);
            s_d.on_len = s_d.gate ? PER_W'(1) : '0;
            s_d.seen   = 1'b0;
        end else if (s_q.gate) begin
            s_d.seen = s_q.seen | trip_ok;
            if (hit_max || (min_ok && (min_mode_i || s_d.seen))) begin
                s_d.gate = 1'b0;
            end else begin
                s_d.on_len = s_q.on_len + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gate_o = s_q.gate;

    // R5: never beyond the ceiling
    a_r5_within_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.gate |-> (s_q.on_len <= s_q.maxon));

    // R4: rise only at a period boundary
    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.gate) |-> $past(tick_i));

    // R10: no start while skipping
    a_r10_skip_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && skip_i) |=> !s_q.gate);

    // R11: enable low forces the gate off
    a_r11_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !s_q.gate);

    // R8: pulses end no earlier than the minimum on-time
    a_r8_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(s_q.gate) && $past(en_i)) |->
        (($past(s_q.on_len) >= MIN_L) || ($past(s_q.on_len) >= $past(s_q.maxon))));

endmodule

// File: rtl/pwm_duty_limiter.sv
module pwm_duty_limiter #(
    parameter int PER_W      = 12,
    parameter int BLANK_CYC  = 20,
    parameter int MIN_ON_CYC = 40,
    parameter int JIT_NUM    = 13,
    parameter int JIT_EVERY  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_nom_i,
    input  logic [1:0]       variant_i,
    input  logic             en_i,
    input  logic             cs_trip_i,
    input  logic             ss_trip_i,
    input  logic             fb_above_min_i,
    input  logic             fb_above_skip_i,
    input  logic             fb_above_exit_i,
    output logic             gate_o,
    output logic             tick_o
);
    logic             tick;
    logic [PER_W-1:0] next_len;
    logic             skip;

    pwm_period_jitter #(
        .PER_W    (PER_W),
        .JIT_NUM  (JIT_NUM),
        .JIT_EVERY(JIT_EVERY)
    ) u_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .nom_i     (period_nom_i),
        .tick_o    (tick),
        .next_len_o(next_len)
    );

    pwm_fb_mode u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .fb_above_skip_i(fb_above_skip_i),
        .fb_above_exit_i(fb_above_exit_i),
        .skip_o         (skip)
    );

    pwm_pulse_gate #(
        .PER_W     (PER_W),
        .BLANK_CYC (BLANK_CYC),
        .MIN_ON_CYC(MIN_ON_CYC)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .tick_i    (tick),
        .next_len_i(next_len),
        .variant_i (variant_i),
        .skip_i    (skip),
        .min_mode_i(!fb_above_min_i),
        .trip_i    (cs_trip_i | ss_trip_i),
        .gate_o    (gate_o)
    );

    assign tick_o = tick;

endmodule

// File: tb/pwm_duty_limiter_test.sv
module pwm_duty_limiter_test;
    localparam int PER_W = 12;
    localparam int BLANK = 3;
    localparam int MINON = 5;
    localparam int EVERY = 2;
    localparam int NOM_T = 19;
    localparam int NOM_J = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PER_W-1:0] nom = PER_W'(NOM_T);
    logic [1:0] variant = 2'd0;
    logic en = 1'b1;
    logic cs = 1'b0, ss = 1'b0;
    logic fmin = 1'b1, fskip = 1'b1, fexit = 1'b1;
    logic gate, tick;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_duty_limiter #(
        .PER_W(PER_W), .BLANK_CYC(BLANK), .MIN_ON_CYC(MINON), .JIT_EVERY(EVERY)
    ) uut (
        .clk(clk), .rst_n(rst_n), .period_nom_i(nom), .variant_i(variant),
        .en_i(en), .cs_trip_i(cs), .ss_trip_i(ss), .fb_above_min_i(fmin),
        .fb_above_skip_i(fskip), .fb_above_exit_i(fexit),
        .gate_o(gate), .tick_o(tick)
    );

    // fields: variant, fb mode (0 normal, 1 min, 2 skip), trip source
    // (0 none, 1 cs, 2 ss), trip high-cycle, expected width
    localparam logic [21:0] VEC [14] = '{
        {2'd0, 2'd0, 2'd0, 8'd0,  8'd9},   // R3 half ceiling
        {2'd1, 2'd0, 2'd0, 8'd0,  8'd15},  // R3 eighty
        {2'd2, 2'd0, 2'd0, 8'd0,  8'd12},  // R3 sixty-five
        {2'd3, 2'd0, 2'd0, 8'd0,  8'd8},   // R3 low
        {2'd1, 2'd0, 2'd1, 8'd2,  8'd15},  // R7 inside blanking
        {2'd1, 2'd0, 2'd1, 8'd3,  8'd15},  // R7 last blanked cycle
        {2'd1, 2'd0, 2'd1, 8'd4,  8'd5},   // R8 trip before min on-time
        {2'd1, 2'd0, 2'd2, 8'd7,  8'd7},   // R6 soft-start trip
        {2'd1, 2'd0, 2'd1, 8'd10, 8'd10},  // R6 sense trip
        {2'd3, 2'd0, 2'd2, 8'd12, 8'd8},   // R5 trip after ceiling
        {2'd1, 2'd1, 2'd0, 8'd0,  8'd5},   // R9 min mode
        {2'd2, 2'd2, 2'd0, 8'd0,  8'd0},   // R10 skip
        {2'd0, 2'd1, 2'd1, 8'd4,  8'd5},   // R9 min mode with trip
        {2'd3, 2'd0, 2'd1, 8'd6,  8'd6}    // R6 trip below ceiling
    };

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_fb(input int m);
        fmin  = (m == 0);
        fskip = (m != 2);
        fexit = (m != 2);
    endtask

    task automatic run_period(input int tsel, input int tat, input int drop,
                              output int w);
        do @(negedge clk); while (!tick);
        w = 0;
        for (int i = 0; i < NOM_T; i++) begin
            @(negedge clk);
            cs = 1'b0;
            ss = 1'b0;
            if (gate) w++;
            if (gate && w == tat) begin
                if (tsel == 1) cs = 1'b1;
                else if (tsel == 2) ss = 1'b1;
            end
            if (gate && w == drop) en = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int w;
        repeat (4) @(negedge clk);
        check("R12 gate low in reset", int'(gate), 0);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            variant = VEC[i][21:20];
            set_fb(int'(VEC[i][19:18]));
            run_period(int'(VEC[i][17:16]), int'(VEC[i][15:8]), 0, w);
            check($sformatf("R3/R4/R5/R6/R7/R8/R9/R10 vector %0d", i),
                  w, int'(VEC[i][7:0]));
        end

        // R10: hysteresis band from both sides
        variant = 2'd3;
        set_fb(2);
        run_period(0, 0, 0, w);
        check("R10 below skip level", w, 0);
        fskip = 1'b1; fexit = 1'b0; fmin = 1'b1;
        run_period(0, 0, 0, w);
        check("R10 band while skipping", w, 0);
        fexit = 1'b1;
        run_period(0, 0, 0, w);
        check("R10 exit above hysteresis", w, 8);
        fexit = 1'b0;
        run_period(0, 0, 0, w);
        check("R10 band while running", w, 8);
        fexit = 1'b1;

        // R11: enable
        en = 1'b0;
        run_period(0, 0, 0, w);
        check("R11 disabled no pulse", w, 0);
        en = 1'b1;
        variant = 2'd1;
        run_period(0, 0, 3, w);
        check("R11 enable dropped mid-pulse", w, 3);
        en = 1'b1;

        // R1/R2: jitter sweep after a fresh reset
        @(negedge clk);
        rst_n = 1'b0;
        nom = PER_W'(NOM_J);
        variant = 2'd1;
        set_fb(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R12 first period starts at release", int'(tick), 1);
        begin
            int amp = (NOM_J * 13) >> 8;
            int off = 0;
            int stp = 0;
            bit up = 1'b1;
            for (int k = 0; k < 12; k++) begin
                int len, c, h;
                if (stp == EVERY - 1) begin
                    stp = 0;
                    if (up) begin
                        if (off < amp) off++;
                        else begin up = 1'b0; if (off > -amp) off--; end
                    end else begin
                        if (off > -amp) off--;
                        else begin up = 1'b1; if (off < amp) off++; end
                    end
                end else stp++;
                len = NOM_J + off;
                c = 0;
                h = 0;
                do begin
                    @(negedge clk);
                    c++;
                    if (gate) h++;
                end while (!tick);
                check($sformatf("R1/R2 period %0d length", k), c, len);
                check($sformatf("R3/R4 period %0d ceiling", k), h, (len * 204) >> 8);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule